// File: doc/BRIEF.md
# Bit-Serial Adder with Parallel Operand Load

This block adds two 8-bit unsigned operands using one single-bit full adder that is reused over eight clock cycles. Each operand sits in its own shift register. A single `load` pulse fills both registers at once from the parallel operand inputs, and the same pulse copies the incoming carry into the carry flip-flop. After `start`, the block shifts both operands right by one place per clock. It adds the two bits that leave the low end together with the stored carry. The sum bit enters the top of a result shift register, and the new carry is kept for the next bit.

After eight shifts the result register holds the aligned 8-bit sum, the carry flip-flop holds the final carry, and `done` goes high. The block then holds its outputs until the next `load`. A caller drives `load` once, drives `start` once, and waits for `done`. It can abort a run at any time by loading new operands.

Top module: `bit_serial_adder`

## Requirements
- R1: Reset is synchronous and active high. The edge after `rst` is sampled high leaves `sum` = 0, `carryOut` = 0 and `done` = 0.
- R2: A clock edge with `load` high captures both operands in that single cycle and makes `carryOut` equal to `carryIn`. It also clears `sum` to 0 and drops `done`.
- R3: The edge that samples `start` (with `load` low, after a load, while no run is active) begins a run. `done` stays low through the next seven edges and rises on the eighth, which is the eighth shift.
- R4: When `done` is high, `sum` equals bits 7..0 and `carryOut` equals bit 8 of opA + opB + carryIn, all taken at the load.
- R5: Operands are consumed least significant bit first. After k shifts (1 ≤ k ≤ 8), `sum` equals the low k bits of the total, placed in `sum[7:8-k]`, with zeros below them. `carryOut` equals the carry out of the low k bit positions.
- R6: While `done` is high and `load` is low, `done`, `sum` and `carryOut` hold their values, and `start` has no effect.
- R7: `load` takes priority over `start`. When both are high on the same edge, no run begins. A load during a run abandons that run, and the next run uses the new operands.
- R8: A `start` pulse during a run neither restarts nor extends it. `done` still rises on the eighth shift counted from the first `start`.
- R9: `opA`, `opB` and `carryIn` are ignored on edges where `load` is low. Changing them during or after a run leaves `sum` and `carryOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Parallel-load both operands and the carry-in |
| start | input | 1 | Begin the serial addition of the loaded operands |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | 8 | Result shift register |
| carryOut | output | 1 | Carry flip-flop; final carry once `done` is high |
| done | output | 1 | High after the eighth shift until the next load or reset |

## Verification
The hardest situations to reach from the ports are the ones where a control pulse lands in the middle of a run: a second `start` partway through the shifts, and a `load` that abandons a partly finished addition. The bench places these pulses a set number of edges after the accepted `start`. It then checks that `done` still appears exactly eight shifts after the first `start`, and that an abandoned run leaves no trace in the carry or the result. It also samples `sum` after every single shift, so that a wrong shift direction or a wrong bit order shows up before the final value hides it.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;   // capture operands, seed carry, clear result
    logic shiftEn;  // advance one bit position
  } bsa_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } bsa_state_t;

endpackage

// File: rtl/bsa_full_adder.sv
module bsa_full_adder (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
  end
endmodule

// File: rtl/bsa_shift_reg.sv
// Right-shifting operand register with single-cycle parallel load.
module bsa_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         loadEn,
  input  logic [W-1:0] loadVal,
  input  logic         shiftEn,
  output logic         lsb
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (loadEn)  q <= loadVal;
    else if (shiftEn) q <= {1'b0, q[W-1:1]};
  end

  assign lsb = q[0];
endmodule

// File: rtl/bsa_datapath.sv
module bsa_datapath
  import bsa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  bsa_strobe_t  strobe,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W-1:0] sum,
  output logic         carryOut
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][W-1:0] opVals;
  logic [NOPS-1:0]        opBits;
  logic                   sumBit;
  logic                   nextCarry;
  logic                   carryQ;
  logic [W-1:0]           resQ;

  assign opVals[0] = opA;
  assign opVals[1] = opB;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    bsa_shift_reg #(.W(W)) u_opReg (
      .clk     (clk),
      .rst     (rst),
      .loadEn  (strobe.loadEn),
      .loadVal (opVals[i]),
      .shiftEn (strobe.shiftEn),
      .lsb     (opBits[i])
    );
  end

  bsa_full_adder u_fa (
    .x  (opBits[0]),
    .y  (opBits[1]),
    .ci (carryQ),
    .s  (sumBit),
    .co (nextCarry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carryQ <= 1'b0;
      resQ   <= '0;
    end else if (strobe.loadEn) begin
      carryQ <= carryIn;
      resQ   <= '0;
    end else if (strobe.shiftEn) begin
      carryQ <= nextCarry;
      resQ   <= {sumBit, resQ[W-1:1]};
    end
  end

  assign sum      = resQ;
  assign carryOut = carryQ;
endmodule

// File: rtl/bsa_control.sv
module bsa_control
  import bsa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic        start,
  output bsa_strobe_t strobe,
  output logic        done
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  bsa_state_t    state, stateNext;
  logic [CW-1:0] bitCnt;

  always_comb begin
    stateNext      = state;
    strobe.loadEn  = load;
    strobe.shiftEn = 1'b0;
    if (load) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (start) stateNext = ST_RUN;
        ST_RUN: begin
          strobe.shiftEn = 1'b1;
          if (bitCnt == LAST) stateNext = ST_FIN;
        end
        ST_FIN:  stateNext = ST_FIN;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state <= stateNext;
      if (load)                bitCnt <= '0;
      else if (strobe.shiftEn) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign done = (state == ST_FIN);
endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder
  import bsa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         start,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W-1:0] sum,
  output logic         carryOut,
  output logic         done
);
  bsa_strobe_t strobe;

  bsa_control #(.W(W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  bsa_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sum      (sum),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic         start,
  input logic         carryIn,
  input logic [W-1:0] sum,
  input logic         carryOut,
  input logic         done
);
  localparam int CW = $clog2(W) + 1;

  // Independent run tracker built from port activity only
  logic          running;
  logic [CW-1:0] chkCnt;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      running <= 1'b0;
      chkCnt  <= '0;
    end else if (!running && !done && start) begin
      running <= 1'b1;
      chkCnt  <= '0;
    end else if (running) begin
      if (done) running <= 1'b0;
      else      chkCnt  <= chkCnt + 1'b1;
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (sum == '0 && !carryOut && !done));

  // R2
  load_seeds_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (sum == '0 && carryOut == $past(carryIn) && !done));

  // R3
  done_timing_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (chkCnt == CW'(W)));

  // R6
  hold_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> (done && $stable(sum) && $stable(carryOut)));
endmodule

bind bit_serial_adder bsa_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load     (load),
  .start    (start),
  .carryIn  (carryIn),
  .sum      (sum),
  .carryOut (carryOut),
  .done     (done)
);

// File: tb/bit_serial_adder_bench.sv
module bit_serial_adder_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst, load, start, carryIn;
  logic [W-1:0] opA, opB;
  logic [W-1:0] sum;
  logic         carryOut, done;

  int compared   = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  bit_serial_adder #(.W(W)) u_bit_serial_adder (
    .clk(clk), .rst(rst), .load(load), .start(start),
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sum(sum), .carryOut(carryOut), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doLoad(input int a, input int b, input bit ci);
    load = 1'b1; opA = W'(a); opB = W'(b); carryIn = ci;
    tick();
    load = 1'b0;
    check(sum == 0, "R2 sum cleared", int'(sum), 0);
    check(carryOut == ci, "R2 carry seeded", int'(carryOut), int'(ci));
    check(!done, "R2 done low", int'(done), 0);
  endtask

  task automatic pulseStart();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  // Shift k times from current point, checking partial results
  task automatic shiftAndCheck(input int a, input int b, input bit ci, input int fromK, input int toK);
    for (int k = fromK; k <= toK; k++) begin
      int mask, tot, expS, expC;
      tick();
      mask = (1 << k) - 1;
      tot  = a + b + int'(ci);
      expS = ((tot & mask) << (W - k)) & 'hFF;
      expC = (((a & mask) + (b & mask) + int'(ci)) >> k) & 1;
      check(int'(sum) == expS, "R5 partial sum", int'(sum), expS);
      check(int'(carryOut) == expC, "R5 partial carry", int'(carryOut), expC);
      check(done == (k == W), "R3 done timing", int'(done), int'(k == W));
    end
  endtask

  task automatic checkFinal(input int a, input int b, input bit ci);
    int tot;
    tot = a + b + int'(ci);
    check(int'(sum) == (tot & 'hFF), "R4 sum", int'(sum), tot & 'hFF);
    check(int'(carryOut) == ((tot >> W) & 1), "R4 carry", int'(carryOut), (tot >> W) & 1);
  endtask

  task automatic runAdd(input int a, input int b, input bit ci);
    doLoad(a, b, ci);
    pulseStart();
    shiftAndCheck(a, b, ci, 1, W);
    checkFinal(a, b, ci);
  endtask

  task automatic testReset();
    rst = 1'b1; load = 0; start = 0; opA = '1; opB = '1; carryIn = 1;
    tick(); tick();
    check(sum == 0 && !carryOut && !done, "R1 reset state",
          int'({done, carryOut, sum}), 0);
    rst = 1'b0;
  endtask

  task automatic testHoldAfterDone();
    logic [W-1:0] s0; logic c0;
    runAdd('h9C, 'h7B, 1'b1);
    s0 = sum; c0 = carryOut;
    pulseStart();
    opA = 'h11; opB = 'h22; carryIn = 0;
    repeat (5) tick();
    check(done, "R6 done held", int'(done), 1);
    check(sum == s0, "R6 sum held", int'(sum), int'(s0));
    check(carryOut == c0, "R9 carry held", int'(carryOut), int'(c0));
  endtask

  task automatic testOperandChangeDuringRun();
    doLoad('hC3, 'h5E, 1'b0);
    pulseStart();
    shiftAndCheck('hC3, 'h5E, 1'b0, 1, 3);
    opA = 'h00; opB = 'hFF; carryIn = 1;
    shiftAndCheck('hC3, 'h5E, 1'b0, 4, W);
    checkFinal('hC3, 'h5E, 1'b0); // R9
  endtask

  task automatic testLoadStartTogether();
    load = 1'b1; start = 1'b1; opA = 'hF0; opB = 'h0F; carryIn = 1;
    tick();
    load = 1'b0; start = 1'b0;
    repeat (10) tick();
    check(!done && sum == 0, "R7 load beats start", int'({done, sum}), 0);
    pulseStart();
    shiftAndCheck('hF0, 'h0F, 1'b1, 1, W);
    checkFinal('hF0, 'h0F, 1'b1);
  endtask

  task automatic testAbortReload();
    doLoad('hFF, 'hFF, 1'b1);
    pulseStart();
    shiftAndCheck('hFF, 'hFF, 1'b1, 1, 3);
    doLoad('h21, 'h34, 1'b0); // R7 abort
    repeat (3) tick();
    check(!done && sum == 0, "R7 abort idle", int'({done, sum}), 0);
    pulseStart();
    shiftAndCheck('h21, 'h34, 1'b0, 1, W);
    checkFinal('h21, 'h34, 1'b0);
  endtask

  task automatic testStartDuringRun();
    doLoad('hA7, 'h6D, 1'b1);
    pulseStart();
    shiftAndCheck('hA7, 'h6D, 1'b1, 1, 3);
    start = 1'b1; // R8 second start
    shiftAndCheck('hA7, 'h6D, 1'b1, 4, 4);
    start = 1'b0;
    shiftAndCheck('hA7, 'h6D, 1'b1, 5, W);
    checkFinal('hA7, 'h6D, 1'b1);
  endtask

  task automatic testResetMidRun();
    doLoad('h77, 'h99, 1'b1);
    pulseStart();
    repeat (4) tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check(sum == 0 && !carryOut && !done, "R1 reset mid-run",
          int'({done, carryOut, sum}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst = 1'b1; load = 0; start = 0; opA = '0; opB = '0; carryIn = 0;
    @(negedge clk);
    testReset();
    runAdd('h00, 'h00, 1'b0);
    runAdd('hFF, 'h01, 1'b0);
    runAdd('hFF, 'hFF, 1'b1);
    runAdd('h5A, 'hA5, 1'b1);
    runAdd('h80, 'h80, 1'b0);
    runAdd('h3C, 'h19, 1'b1);
    testHoldAfterDone();
    testOperandChangeDuringRun();
    testLoadStartTogether();
    testAbortReload();
    testStartDuringRun();
    testResetMidRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule